// File: doc/BRIEF.md
# Dual-Rail Two-Phase Word Receiver

This block turns a bus of N bits, each carried on two wires, back into a plain N-bit word for a consumer in the receiver's clock domain. Every bit has a value wire and a companion wire. The companion wire equals the value wire in the even phase and is its inverse in the odd phase. Successive words alternate between the two phases, so a sender moves each bit to a new word by toggling exactly one of its two wires.

The receiver keeps a record of which phase it expects next. Each bit has its own phase detector. The receiver stores the value-wire vector only in a cycle where every bit shows the expected phase. A bit that is still in the old phase holds the capture back. After a capture the stored word is offered with a valid flag, and the flag stays high until the consumer acknowledges it. The expected phase then flips once, ready for the next word. The rails are assumed to be synchronized into the receiver clock already. A capture-enable input gives the consumer a way to hold off capture.

Top module: `ledr_receiver`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `word_valid` is 0 and `word_out` is 0. The expected phase after reset is even, so rails that all show the odd phase (companion wire = inverse of value wire) cause no capture.
- R2: A bit is in the even phase when its companion wire equals its value wire, and in the odd phase when the two wires differ.
- R3: While at least one bit does not yet show the expected phase, no capture takes place. Bits changed one per cycle in any order leave `word_valid` at 0 until the last bit has changed.
- R4: If every bit shows the expected phase at a rising clock edge, and capture is allowed, then after that edge `word_valid` is 1 and `word_out` equals the value-wire vector sampled at that edge.
- R5: The expected phase toggles exactly once per captured word. Once a word in one phase has been taken, a different word presented in that same phase is not captured.
- R6: While `word_valid` is 1 and `word_ack` is 0, `word_valid` stays 1 and `word_out` does not change.
- R7: While a word is held, no new capture takes place, even if the rails show the expected phase. An edge with `word_ack` high clears `word_valid`. A matching word is then captured on the following edge.
- R8: While `cap_en` is 0, nothing is captured. A fully matching word is captured on the first edge after `cap_en` returns to 1.
- R9: A `word_ack` pulse while `word_valid` is 0 has no effect: it neither raises `word_valid` nor disturbs the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_en | input | 1 | Capture is allowed when 1 |
| rail_val | input | WIDTH | Value wire of each bit |
| rail_cmp | input | WIDTH | Companion wire of each bit |
| word_ack | input | 1 | Consumer has taken the held word |
| word_out | output | WIDTH | Last captured value-wire vector |
| word_valid | output | 1 | A captured word is held and not yet acknowledged |

## Verification
The hardest situation to reach is a word that is partly in the new phase and partly in the old one. The sender's wires normally move together, so this mix does not arise on its own. The stimulus moves each bit separately, one per clock, in a rotating order. At each intermediate step the bench confirms that nothing has been captured. It runs this over every word value of a four-bit configuration, alternating phases. Extra sequences present a fully matching word while a word is still held, while capture is disabled, and in the phase just consumed.

// File: rtl/ledr_rx_pkg.sv
// Package: shared types for the dual-rail two-phase receiver.
// Assumes nothing beyond a one-bit phase encoding: 0 = even, 1 = odd.
package ledr_rx_pkg;

    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } ledr_phase_e;

    // Return the phase that follows the given one.
    function automatic ledr_phase_e next_phase(input ledr_phase_e ph);
        return (ph == PH_EVEN) ? PH_ODD : PH_EVEN;
    endfunction

endpackage

// File: rtl/ledr_bit_phase.sv
// Module: per-bit phase detector.
// Reports whether one bit's two wires show the even phase (wires equal)
// or the odd phase (wires differ). Pure combinational logic.
// Assumes the wires are already stable in the receiver clock domain.
module ledr_bit_phase (
    input  logic val_i,
    input  logic cmp_i,
    output logic is_even_o,
    output logic is_odd_o
);

    // Classify the pair of wires into one of the two phases.
    always_comb begin
        is_even_o = (val_i == cmp_i);
        is_odd_o  = (val_i != cmp_i);
    end

endmodule

// File: rtl/ledr_completion.sv
// Module: word-level completion detector.
// Has one phase detector per bit, combines the even and odd results
// across all bits, and reports a match when every bit shows the
// expected phase. Combinational. Assumes WIDTH >= 1.
module ledr_completion
    import ledr_rx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] rail_val_i,
    input  logic [WIDTH-1:0] rail_cmp_i,
    input  ledr_phase_e      expect_i,
    output logic             all_even_o,
    output logic             all_odd_o,
    output logic             match_o
);

    logic [WIDTH-1:0] even_vec;
    logic [WIDTH-1:0] odd_vec;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        ledr_bit_phase u_bit (
            .val_i     (rail_val_i[b]),
            .cmp_i     (rail_cmp_i[b]),
            .is_even_o (even_vec[b]),
            .is_odd_o  (odd_vec[b])
        );
    end

    // Reduce per-bit results and select the one for the expected phase.
    always_comb begin
        all_even_o = &even_vec;
        all_odd_o  = &odd_vec;
        match_o    = (expect_i == PH_EVEN) ? all_even_o : all_odd_o;
    end

endmodule

// File: rtl/ledr_capture_reg.sv
// Module: capture register, hold flag and expected-phase tracker.
// Stores the value-wire vector when a match is reported, capture is
// enabled and no word is held. It then keeps the word until it is
// acknowledged. The expected phase flips once per capture.
// Synchronous active-low reset; the expected phase resets to even.
module ledr_capture_reg
    import ledr_rx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en_i,
    input  logic             match_i,
    input  logic [WIDTH-1:0] rail_val_i,
    input  logic             ack_i,
    output logic [WIDTH-1:0] word_o,
    output logic             valid_o,
    output ledr_phase_e      expect_o
);

    logic take;

    // Decide whether this edge stores a new word.
    always_comb begin
        take = match_i && cap_en_i && !valid_o;
    end

    // Update the held word, the hold flag and the expected phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o   <= '0;
            valid_o  <= 1'b0;
            expect_o <= PH_EVEN;
        end else if (take) begin
            word_o   <= rail_val_i;
            valid_o  <= 1'b1;
            expect_o <= next_phase(expect_o);
        end else if (valid_o && ack_i) begin
            valid_o  <= 1'b0;
        end
    end

    // R6
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ack_i) |=> (valid_o && $stable(word_o)));

    // R7
    no_recapture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> $stable(expect_o));

    // R8
    enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en_i && !valid_o) |=> !valid_o);

endmodule

// File: rtl/ledr_receiver.sv
// Module: top of the dual-rail two-phase word receiver.
// Joins the completion detector to the capture register. The rails
// must already be synchronized to clk. A word is offered on word_out
// with word_valid until word_ack is seen at a clock edge.
module ledr_receiver
    import ledr_rx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic [WIDTH-1:0] rail_val,
    input  logic [WIDTH-1:0] rail_cmp,
    input  logic             word_ack,
    output logic [WIDTH-1:0] word_out,
    output logic             word_valid
);

    ledr_phase_e expect_ph;
    logic        all_even;
    logic        all_odd;
    logic        match;

    ledr_completion #(.WIDTH(WIDTH)) u_done (
        .rail_val_i (rail_val),
        .rail_cmp_i (rail_cmp),
        .expect_i   (expect_ph),
        .all_even_o (all_even),
        .all_odd_o  (all_odd),
        .match_o    (match)
    );

    ledr_capture_reg #(.WIDTH(WIDTH)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en_i   (cap_en),
        .match_i    (match),
        .rail_val_i (rail_val),
        .ack_i      (word_ack),
        .word_o     (word_out),
        .valid_o    (word_valid),
        .expect_o   (expect_ph)
    );

    // R3
    capture_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid) |-> $past(match));

    // R4
    capture_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid) |-> (word_out == $past(rail_val)));

    // R2
    phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(all_even && all_odd));

endmodule

// File: tb/ledr_receiver_bench.sv
module ledr_receiver_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_en = 1'b1;
    logic [W-1:0] rail_val = '0;
    logic [W-1:0] rail_cmp = '1;
    logic         word_ack = 1'b0;
    logic [W-1:0] word_out;
    logic         word_valid;

    int checks = 0;
    int errors = 0;
    int cur_ph = 1; // phase the rails currently show: 0 even, 1 odd

    always #5 clk = ~clk;

    ledr_receiver #(.WIDTH(W)) u_ledr_receiver (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .rail_val   (rail_val),
        .rail_cmp   (rail_cmp),
        .word_ack   (word_ack),
        .word_out   (word_out),
        .word_valid (word_valid)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Move one bit to value v in phase ph (companion = value for even).
    task automatic set_bit(input int b, input logic v, input int ph);
        rail_val[b] = v;
        rail_cmp[b] = (ph == 0) ? v : ~v;
    endtask

    task automatic set_word(input logic [W-1:0] w, input int ph);
        for (int b = 0; b < W; b++) set_bit(b, w[b], ph);
    endtask

    task automatic do_ack();
        word_ack = 1'b1;
        tick();
        word_ack = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] hold_w;
        @(negedge clk);
        set_word('0, 1);
        tick(); tick();
        chk(word_valid == 1'b0, "R1", word_valid, 0);
        chk(word_out == '0, "R1", word_out, 0);
        rst_n = 1'b1;
        tick();
        chk(word_valid == 1'b0, "R1", word_valid, 0);
        chk(word_out == '0, "R1", word_out, 0);

        // R3 R4 R6 R2: staggered sweep of all word values, alternating phase
        for (int w = 0; w < (1 << W); w++) begin
            int nph;
            nph = 1 - cur_ph;
            for (int j = 0; j < W; j++) begin
                int b;
                b = (j + w) % W;
                set_bit(b, w[b], nph);
                tick();
                if (j < W - 1)
                    chk(word_valid == 1'b0, "R3", word_valid, 0);
            end
            cur_ph = nph;
            chk(word_valid == 1'b1, "R4", word_valid, 1);
            chk(word_out == W'(w), "R4", word_out, w);
            tick();
            chk(word_valid == 1'b1 && word_out == W'(w), "R6", word_out, w);
            do_ack();
            chk(word_valid == 1'b0, "R7", word_valid, 0);
        end

        // R5: another word in the phase just consumed is ignored
        set_word(4'hA, cur_ph);
        tick(); tick(); tick();
        chk(word_valid == 1'b0, "R5", word_valid, 0);
        chk(word_out == 4'hF, "R5", word_out, 4'hF);

        // R7: a matching word while one is held waits for the ack
        cur_ph = 1 - cur_ph;
        set_word(4'h5, cur_ph);
        tick();
        chk(word_valid == 1'b1 && word_out == 4'h5, "R7", word_out, 4'h5);
        cur_ph = 1 - cur_ph;
        set_word(4'h9, cur_ph);
        tick(); tick();
        chk(word_out == 4'h5, "R7", word_out, 4'h5);
        word_ack = 1'b1;
        tick();
        word_ack = 1'b0;
        chk(word_valid == 1'b0, "R7", word_valid, 0);
        tick();
        chk(word_valid == 1'b1 && word_out == 4'h9, "R7", word_out, 4'h9);
        do_ack();

        // R8: capture enable low blocks a matching word
        cap_en = 1'b0;
        cur_ph = 1 - cur_ph;
        set_word(4'h6, cur_ph);
        tick(); tick(); tick();
        chk(word_valid == 1'b0, "R8", word_valid, 0);
        cap_en = 1'b1;
        tick();
        chk(word_valid == 1'b1 && word_out == 4'h6, "R8", word_out, 4'h6);
        do_ack();

        // R9: ack with nothing held has no effect
        hold_w = word_out;
        do_ack();
        tick();
        chk(word_valid == 1'b0 && word_out == hold_w, "R9", word_valid, 0);
        cur_ph = 1 - cur_ph;
        set_word(4'h3, cur_ph);
        tick();
        chk(word_valid == 1'b1 && word_out == 4'h3, "R9", word_out, 4'h3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule